// File: doc/BRIEF.md
# Delay-Line Snapshot Time Stamp Encoder

This block converts one clock-edge snapshot of a tapped delay line into a time stamp. The measured signal travels down a chain of delay cells, and every tap is latched on the rising edge of the system clock. Taps that the new level has already reached hold that new level. Taps it has not yet reached still hold the old level. The position where the level changes therefore gives the time between the signal edge and the clock edge, in units of one delay cell (roughly 15 ps).

The snapshot may contain stray wrong bits close to the change. These come from metastable capture or from unequal wiring to the latches. For that reason a transition is accepted only where a clean run of equal taps lies on both sides of it. Both rising and falling transitions are located, so leading and trailing times of a pulse can both be recorded.

The block combines the tap index of the accepted transition with the coarse clock count sampled in the same cycle. It presents the time stamp, the edge polarity and a one-cycle valid strobe two clocks after capture. A reference channel for synchronising several boards is simply one more instance of this block.

Top module: `tdl_stamp_encoder`

## Requirements
- R1: While reset is asserted, and after it is released until the first stamp is produced, `valid_o` is 0, `stamp_o` is 0 and `rising_o` is 0.
- R2: Tap 0 is the first tap along the chain, and bit i of `tap_snap` is tap i. A rising transition at position p exists when taps p-3..p-1 are all 1 and taps p..p+2 are all 0. It is reported with fine value p and `rising_o` = 1.
- R3: A falling transition at position p exists when taps p-3..p-1 are all 0 and taps p..p+2 are all 1. It is reported with fine value p and `rising_o` = 0.
- R4: Transitions are declared only where the run on each side is complete. A single wrong bit inside a run does not create a transition. A stray bit within three taps of the change suppresses that transition. As a result, the fine value is always between 3 and 61.
- R5: A snapshot with no qualifying transition, such as all zeros or all ones, produces no valid strobe.
- R6: When several transitions qualify, the one with the lowest tap index is reported, whatever its polarity.
- R7: The valid strobe for a snapshot is high for exactly one cycle, in the second clock after the capture edge. Snapshots on consecutive cycles give strobes on consecutive cycles.
- R8: `stamp_o` is {coarse, fine}. The coarse field (bits 21:6) is the `coarse_cnt` value sampled on the same edge as the taps, including the all-ones value 0xFFFF. The fine field is bits 5:0.
- R9: In a cycle without a valid strobe, `stamp_o` and `rising_o` keep the values of the last reported stamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; its rising edge is the start reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_snap | input | 64 | Delay-line tap levels, bit i is tap i |
| coarse_cnt | input | 16 | Free-running coarse clock count |
| stamp_o | output | 22 | Time stamp {coarse, fine} |
| rising_o | output | 1 | 1 for a rising transition, 0 for a falling one |
| valid_o | output | 1 | One-cycle strobe: a stamp is present |

## Verification
The bench builds the block with its defaults: 64 taps, a run length of 3 and a 16-bit coarse count. With these values both ends of the legal fine range, 3 and 61, can be reached with one-tap-off neighbours that must be rejected. Bubbles can be placed just inside and just outside the three-tap guard. The coarse field can be driven to its all-ones value. Back-to-back snapshots and quiet cycles are mixed, so that both the strobe timing and the hold behaviour are visible at the ports.

// File: rtl/tdl_stamp_encoder.sv
module tdl_stamp_encoder #(
  parameter int TAPS     = 64,
  parameter int COARSE_W = 16,
  parameter int RUN      = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [TAPS-1:0]                        tap_snap,
  input  logic [COARSE_W-1:0]                    coarse_cnt,
  output logic [COARSE_W+$clog2(TAPS)-1:0]       stamp_o,
  output logic                                   rising_o,
  output logic                                   valid_o
);
  localparam int FINE_W = $clog2(TAPS);
  localparam int TS_W   = COARSE_W + FINE_W;
  localparam int P_LO   = RUN;
  localparam int P_HI   = TAPS - RUN;

  logic [TAPS-1:0]     cap_q;
  logic [COARSE_W-1:0] cap_coarse_q;
  logic [TAPS-1:0]     rise_hit, fall_hit;
  logic                found_c, rise_c;
  logic [FINE_W-1:0]   pos_c;

  logic                hit_s1, rise_s1;
  logic [FINE_W-1:0]   pos_s1;
  logic [COARSE_W-1:0] coarse_s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q        <= '0;
      cap_coarse_q <= '0;
    end else begin
      cap_q        <= tap_snap;
      cap_coarse_q <= coarse_cnt;
    end
  end

  genvar p;
  generate
    for (p = 0; p < TAPS; p++) begin : g_win
      if (p >= P_LO && p <= P_HI) begin : g_on
        assign rise_hit[p] = (&cap_q[p-1 -: RUN]) & ~(|cap_q[p +: RUN]);
        assign fall_hit[p] = ~(|cap_q[p-1 -: RUN]) & (&cap_q[p +: RUN]);
      end else begin : g_off
        assign rise_hit[p] = 1'b0;
        assign fall_hit[p] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    found_c = 1'b0;
    rise_c  = 1'b0;
    pos_c   = '0;
    for (int i = TAPS - 1; i >= 0; i--) begin
      if (rise_hit[i] || fall_hit[i]) begin
        found_c = 1'b1;
        rise_c  = rise_hit[i];
        pos_c   = FINE_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_s1    <= 1'b0;
      rise_s1   <= 1'b0;
      pos_s1    <= '0;
      coarse_s1 <= '0;
    end else begin
      hit_s1    <= found_c;
      rise_s1   <= rise_c;
      pos_s1    <= pos_c;
      coarse_s1 <= cap_coarse_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      rising_o <= 1'b0;
      stamp_o  <= '0;
    end else begin
      valid_o <= hit_s1;
      if (hit_s1) begin
        rising_o <= rise_s1;
        stamp_o  <= {coarse_s1, pos_s1};
      end
    end
  end

  a_r4_fine_range: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (int'(stamp_o[FINE_W-1:0]) >= P_LO && int'(stamp_o[FINE_W-1:0]) <= P_HI));

  a_r8_coarse_align: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (stamp_o[TS_W-1:FINE_W] == $past(coarse_cnt, 3)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(stamp_o) && $stable(rising_o)));

  a_r5_flat_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($past(cap_q, 2) != '0 && $past(cap_q, 2) != '1));

  a_r7_from_stage: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(found_c, 2));
endmodule

// File: tb/sim_tdl_stamp_encoder.sv
`timescale 1ns/1ps
module sim_tdl_stamp_encoder;
  localparam int TAPS = 64;
  localparam int CW   = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [TAPS-1:0] tap_snap = '0;
  logic [CW-1:0]   coarse_cnt = '0;
  logic [CW+5:0]   stamp_o;
  logic            rising_o, valid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [CW+5:0] last_stamp = '0;
  logic          last_rise  = 1'b0;

  always #2 clk = ~clk;

  tdl_stamp_encoder u0 (
    .clk(clk), .rst_n(rst_n), .tap_snap(tap_snap), .coarse_cnt(coarse_cnt),
    .stamp_o(stamp_o), .rising_o(rising_o), .valid_o(valid_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ones_below(input int n);
    return (n >= 64) ? '1 : ((64'h1 << n) - 64'h1);
  endfunction

  task automatic one_shot(input string req, input logic [63:0] v, input logic [CW-1:0] c,
                          input bit exp_v, input int exp_fine, input bit exp_rise);
    @(negedge clk); tap_snap = v; coarse_cnt = c;
    @(negedge clk); tap_snap = '0; coarse_cnt = c + 16'd7;
    @(negedge clk);
    chk({req, " R7 no early strobe"}, 64'(valid_o), 64'd0);
    @(negedge clk);
    chk({req, " valid"}, 64'(valid_o), 64'(exp_v));
    if (exp_v) begin
      last_stamp = {c, 6'(exp_fine)};
      last_rise  = exp_rise;
    end
    chk({req, " stamp"}, 64'(stamp_o), 64'(last_stamp));
    chk({req, " polarity"}, 64'(rising_o), 64'(last_rise));
    @(negedge clk);
    chk({req, " R7 single strobe"}, 64'(valid_o), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 valid in reset", 64'(valid_o), 64'd0);
    chk("R1 stamp in reset", 64'(stamp_o), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R1 valid after reset", 64'(valid_o), 64'd0);
    chk("R1 polarity after reset", 64'(rising_o), 64'd0);
  endtask

  task automatic t_basic;
    one_shot("R2 rising at 20", ones_below(20), 16'h1234, 1, 20, 1);
    one_shot("R3 falling at 40", ~ones_below(40), 16'h0042, 1, 40, 0);
    one_shot("R8 coarse all-ones", ones_below(33), 16'hFFFF, 1, 33, 1);
  endtask

  task automatic t_bubbles;
    one_shot("R4 far bubble and inner hole", (ones_below(30) & ~(64'h1 << 10)) | (64'h1 << 33),
             16'h0100, 1, 30, 1);
    one_shot("R4 adjacent bubble suppresses", ones_below(30) | (64'h1 << 31), 16'h0101, 0, 0, 0);
    chk("R9 hold after suppressed", 64'(stamp_o), 64'({16'h0100, 6'd30}));
  endtask

  task automatic t_flat;
    one_shot("R5 all zeros", 64'h0, 16'h0200, 0, 0, 0);
    one_shot("R5 all ones", '1, 16'h0201, 0, 0, 0);
  endtask

  task automatic t_bounds;
    one_shot("R4 lowest position 3", ones_below(3), 16'h0300, 1, 3, 1);
    one_shot("R4 position 2 rejected", ones_below(2), 16'h0301, 0, 0, 0);
    one_shot("R4 highest position 61", ones_below(61), 16'h0302, 1, 61, 1);
    one_shot("R4 position 62 rejected", ones_below(62), 16'h0303, 0, 0, 0);
  endtask

  task automatic t_multi;
    one_shot("R6 rising before falling", ones_below(10) | ~ones_below(30), 16'h0400, 1, 10, 1);
    one_shot("R6 falling before rising", ones_below(40) & ~ones_below(15), 16'h0401, 1, 15, 0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk); tap_snap = ones_below(12); coarse_cnt = 16'h0500;
    @(negedge clk); tap_snap = ~ones_below(50); coarse_cnt = 16'h0501;
    @(negedge clk); tap_snap = '0;
    @(negedge clk);
    chk("R7 first strobe", 64'(valid_o), 64'd1);
    chk("R8 first stamp", 64'(stamp_o), 64'({16'h0500, 6'd12}));
    chk("R2 first polarity", 64'(rising_o), 64'd1);
    @(negedge clk);
    chk("R7 second strobe", 64'(valid_o), 64'd1);
    chk("R8 second stamp", 64'(stamp_o), 64'({16'h0501, 6'd50}));
    chk("R3 second polarity", 64'(rising_o), 64'd0);
    @(negedge clk);
    chk("R7 strobe ends", 64'(valid_o), 64'd0);
    chk("R9 stamp held", 64'(stamp_o), 64'({16'h0501, 6'd50}));
    last_stamp = {16'h0501, 6'd50};
    last_rise  = 1'b0;
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_bubbles();
    t_flat();
    t_bounds();
    t_multi();
    t_back_to_back();
    done = 1'b1;
    finish_up();
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end
endmodule